// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits using one full-adder slice and one carry bit. A start strobe loads both operands in parallel into two shift registers and clears the carry. Over the next `WIDTH` clocks the low bits of both registers are added, one pair per clock. Each sum bit is pushed into the top of the first operand register, so that register holds the result when the run ends.

The addend register takes in zeros at its top by default. A parameter can make it recirculate its own low bit instead. A one-clock done pulse marks the end of the run. The result and the final carry are then held until the next accepted start. This suits datapaths where area matters more than latency, because the arithmetic cost is one adder slice whatever the operand width.

Top module: `bsa_serial_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `sum_out` = 0, `carry_out` = 0 and `done` = 0.
- R2: When the run for operands a and b ends, `sum_out` = (a + b) mod 2^WIDTH and `carry_out` = bit WIDTH of a + b.
- R3: `done` goes high exactly WIDTH clocks after the clock edge that accepted `start`, and it stays high for one clock only.
- R4: A `start` that arrives while a run is in progress is ignored. The operands of that run decide the result, and the end of the run does not move.
- R5: When no run is in progress and `start` is low, `sum_out` and `carry_out` keep their values.
- R6: On an accepted start the stored carry is cleared, so `carry_out` is 0 in the clock after the load, even if the previous sum carried.
- R7: The operands are added least significant bit first. After j of the WIDTH shifts, the top j bits of `sum_out` equal the low j bits of a + b, with the bit produced most recently at bit WIDTH-1.
- R8: During each shift the carry becomes 1 when both operand bits are 1 and becomes 0 when both are 0. It keeps its value when the two bits differ.
- R9: The bit shifted into `sum_out[WIDTH-1]` during a shift equals x XOR y XOR carry. Here x and y are the low bits of the two operand registers before the edge, and carry is the stored carry before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load strobe; loads both operands and starts a run when no run is in progress |
| opnd_a | input | WIDTH | First operand; its register receives the sum |
| opnd_b | input | WIDTH | Second operand |
| sum_out | output | WIDTH | Contents of the first operand register; holds the result after the run |
| carry_out | output | 1 | Stored carry; holds the final carry after the run |
| done | output | 1 | One-clock pulse when the last shift has completed |

## Verification
On every shifting cycle the checker confirms several things. The new top bit of the result register is the XOR of the two serial bits and the stored carry. The carry is set, cleared or held according to the two serial bits. The carry is cleared on a load, done never lasts more than one clock, and the outputs stay frozen while the block is idle.

The arithmetic result of a whole run can only be shown by the bench's scenarios. So can the number of clocks from start to done, the order in which partial sums appear, and whether a start during a run is ignored. The bench runs every pair of 4-bit operands and computes the sum arithmetically.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // Next state of a JK-style storage bit driven by the two serial operand bits:
  // set when both are 1, clear when both are 0, otherwise hold.
  function automatic logic carry_next(input logic q, input logic x, input logic y);
    logic j_in;
    logic k_in;
    j_in = x & y;
    k_in = ~x & ~y;
    return (j_in & ~q) | (~k_in & q);
  endfunction

  // One-bit sum of a full-adder slice.
  function automatic logic slice_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

endpackage

// File: rtl/bsa_shift_reg.sv
// Parallel-load right-shift register; the serial input enters at the top.
module bsa_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= {ser_in, q[WIDTH-1:1]};
    end
  end

endmodule

// File: rtl/bsa_serializer.sv
// Parallel-in, serial-out register for the second operand.
// KEEP = 1 recirculates the low bit so the operand survives the run.
module bsa_serializer #(
  parameter int WIDTH = 8,
  parameter bit KEEP  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  output logic             ser_out
);

  logic [WIDTH-1:0] data_q;
  logic             fill_bit;

  generate
    if (KEEP) begin : g_recirc
      assign fill_bit = data_q[0];
    end else begin : g_zero
      assign fill_bit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= load_val;
    end else if (shift) begin
      data_q <= {fill_bit, data_q[WIDTH-1:1]};
    end
  end

  assign ser_out = data_q[0];

endmodule

// File: rtl/bsa_carry_cell.sv
// Single carry storage bit with set/clear/hold next-state rules.
module bsa_carry_cell (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  input  logic x,
  input  logic y,
  output logic q
);
  import bsa_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (clear) begin
      q <= 1'b0;
    end else if (en) begin
      q <= carry_next(q, x, y);
    end
  end

endmodule

// File: rtl/bsa_ctrl.sv
// Counts WIDTH shift cycles after an accepted start and pulses done at the end.
module bsa_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic shift_en,
  output logic done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LOAD_CNT = CW'(WIDTH);
  localparam logic [CW-1:0] LAST_CNT = CW'(1);

  logic [CW-1:0] bits_left;

  assign shift_en = (bits_left != '0);
  assign load     = start & ~shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= shift_en && (bits_left == LAST_CNT);
      if (load) begin
        bits_left <= LOAD_CNT;
      end else if (shift_en) begin
        bits_left <= bits_left - LAST_CNT;
      end
    end
  end

endmodule

// File: rtl/bsa_serial_adder.sv
module bsa_serial_adder #(
  parameter int WIDTH  = 8,
  parameter bit KEEP_B = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             done
);
  import bsa_pkg::*;

  logic             load;
  logic             shift_en;
  logic [WIDTH-1:0] a_q;
  logic             a_sout;
  logic             b_sout;
  logic             carry_q;
  logic             sum_bit;

  bsa_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load     (load),
    .shift_en (shift_en),
    .done     (done)
  );

  assign a_sout  = a_q[0];
  assign sum_bit = slice_sum(a_sout, b_sout, carry_q);

  bsa_shift_reg #(.WIDTH(WIDTH)) reg_a_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (opnd_a),
    .shift    (shift_en),
    .ser_in   (sum_bit),
    .q        (a_q)
  );

  bsa_serializer #(.WIDTH(WIDTH), .KEEP(KEEP_B)) reg_b_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (opnd_b),
    .shift    (shift_en),
    .ser_out  (b_sout)
  );

  bsa_carry_cell carry_i (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .en    (shift_en),
    .x     (a_sout),
    .y     (b_sout),
    .q     (carry_q)
  );

  assign sum_out   = a_q;
  assign carry_out = carry_q;

endmodule

// File: rtl/bsa_serial_adder_chk.sv
module bsa_serial_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             shift_en,
  input logic             x_bit,
  input logic             y_bit,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out,
  input logic             done
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sum_out == '0 && !carry_out && !done)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R3
  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(shift_en)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (!shift_en && !start) |=> ($stable(sum_out) && $stable(carry_out))); // R5
  AST_LOAD_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst) (start && !shift_en) |=> !carry_out); // R6
  AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst) (shift_en && x_bit && y_bit) |=> carry_out); // R8
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst) (shift_en && !x_bit && !y_bit) |=> !carry_out); // R8
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst) (shift_en && (x_bit ^ y_bit)) |=> (carry_out == $past(carry_out))); // R8
  AST_SUM_BIT: assert property (@(posedge clk) disable iff (rst) shift_en |=> (sum_out[WIDTH-1] == $past(x_bit ^ y_bit ^ carry_out))); // R9

endmodule

bind bsa_serial_adder bsa_serial_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .shift_en  (shift_en),
  .x_bit     (a_sout),
  .y_bit     (b_sout),
  .sum_out   (sum_out),
  .carry_out (carry_out),
  .done      (done)
);

// File: tb/bsa_serial_adder_tb_top.sv
`timescale 1ns/1ps
module bsa_serial_adder_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] sum_out;
  logic         carry_out;
  logic         done;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  bsa_serial_adder #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opnd_a    (opa),
    .opnd_b    (opb),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One addition; poke = 1 raises start with other operands in mid-run (R4).
  task automatic run_add(input int a, input int b, input bit poke);
    int n;
    int full;
    int res;
    int cout;
    int held_s;
    int held_c;
    string tag;
    full = a + b;
    res  = full % (1 << W);
    cout = (full >> W) & 1;
    tag  = poke ? "R4" : "R2";
    @(negedge clk);
    opa = W'(a);
    opb = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(carry_out == 1'b0, "R6", "carry after load", int'(carry_out), 0);
    n = 0;
    while (!done && n < W + 4) begin
      if (poke && n == 1) begin
        opa = ~W'(a);
        opb = ~W'(b);
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
      if (!done && n < W) begin
        check((int'(sum_out) >> (W - n)) == (full & ((1 << n) - 1)), "R7",
              "partial sum top bits", int'(sum_out) >> (W - n), full & ((1 << n) - 1));
      end
    end
    check(n == W, "R3", "clocks from load to done", n, W);
    check(int'(sum_out) == res, tag, "sum", int'(sum_out), res);
    check(int'(carry_out) == cout, tag, "carry", int'(carry_out), cout);
    held_s = int'(sum_out);
    held_c = int'(carry_out);
    @(negedge clk);
    check(done == 1'b0, "R3", "done width", int'(done), 0);
    check(int'(sum_out) == held_s && int'(carry_out) == held_c, "R5",
          "result held", int'(sum_out), held_s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sum_out == '0, "R1", "sum after reset", int'(sum_out), 0);
    check(carry_out == 1'b0, "R1", "carry after reset", int'(carry_out), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    rst = 1'b0;

    // R2, R3, R7, R8, R9: every operand pair
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_add(a, b, 1'b0);
      end
    end

    // R6: carry from previous run must not leak into the next
    run_add(15, 15, 1'b0);
    run_add(0, 0, 1'b0);
    run_add(15, 1, 1'b0);
    run_add(2, 3, 1'b0);

    // R4: start during a run is ignored
    run_add(3, 4, 1'b1);
    run_add(9, 9, 1'b1);
    run_add(15, 15, 1'b1);

    // R5: long idle hold
    begin
      int s0;
      int c0;
      s0 = int'(sum_out);
      c0 = int'(carry_out);
      repeat (6) @(negedge clk);
      check(int'(sum_out) == s0, "R5", "idle sum", int'(sum_out), s0);
      check(int'(carry_out) == c0, "R5", "idle carry", int'(carry_out), c0);
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    opa = 4'd7;
    opb = 4'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(sum_out == '0 && carry_out == 1'b0 && done == 1'b0, "R1",
          "reset mid-run", int'(sum_out), 0);
    repeat (W + 2) @(negedge clk);
    check(done == 1'b0 && sum_out == '0, "R1", "no run after reset", int'(sum_out), 0);

    report();
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule